// File: doc/BRIEF.md
# Rotating Victim/Aggressor Lane Stress Generator and Checker

This block drives a parallel data bus, such as the byte lanes of a memory interface, with a stress pattern for signal-integrity testing. One lane at a time is the victim. It carries a short pseudo-random sequence. Every other lane is an aggressor and carries a longer, unrelated pseudo-random sequence, inverted on every second lane, so that neighbouring wires switch against each other as often as possible. After a programmable dwell time the victim role moves to the next lane. Over one sweep, every lane takes the victim position once.

A matching checker receives the looped-back lane data. It runs its own copy of both sequences and of the rotation schedule. Its copy starts a programmable number of cycles after the generator, so that it lines up with the return path. Each lane has a saturating mismatch counter. A start command reseeds everything and clears the counters. A stop command freezes the pattern, the schedule and the counters, so that the results can be read until the next start. A one-cycle flag marks each completed sweep of the generator.

Top module: `lane_stress_gen`

## Requirements
- R1: After reset, all error counters read 0, `done_o` is 0, and `tx_data_o` shows lane 0 low and every other lane equal to its lane-number parity (odd lanes 1, even lanes 0).
- R2: The victim sequence is a 7-bit shift register. Its output bit is bit 6. Each step shifts left and inserts bit6 XOR bit5 at bit 0. At start it loads `seed_i[6:0]`, or 1 if that field is zero.
- R3: The aggressor sequence is a 15-bit shift register. Its output bit is bit 14. Each step shifts left and inserts bit14 XOR bit13 at bit 0. At start it loads `seed_i[14:0]`, or 1 if that field is zero.
- R4: Lane i of `tx_data_o` equals the victim output bit when i is the victim index. Otherwise it equals the aggressor output bit XOR (i mod 2).
- R5: The victim index is 0 after start. It advances by one after `interval_i` transmit cycles, with 0 treated as 1, and wraps from the last lane to lane 0.
- R6: `done_o` is high for exactly one cycle: the cycle after the generator's victim index wraps from the last lane to 0.
- R7: A start clears all error counters and `done_o` in the next cycle and restarts both sequences. Start takes priority over a stop in the same cycle.
- R8: While stopped, `tx_data_o` and every error counter hold their values whatever arrives on `rx_data_i`, until the next start.
- R9: With loopback latency L = `lat_i` sampled at start, the checker compares `rx_data_i` in cycle k against the transmit data of cycle k−L. Mismatches in the first L cycles after start are not counted.
- R10: Each checked cycle adds exactly one to the counter of every lane whose received bit differs from the expected bit. Correctly returned data leaves every counter at 0.
- R11: Each 16-bit counter saturates at 65535 and holds there until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Reseed, clear counters and begin running |
| stop_i | input | 1 | Freeze pattern, schedule and counters |
| seed_i | input | 15 | Seed for both sequences |
| interval_i | input | INTV_W | Cycles each lane stays victim |
| lat_i | input | LAT_W | Loopback latency in cycles |
| rx_data_i | input | LANES | Returned lane data |
| tx_data_o | output | LANES | Transmitted lane data |
| err_cnt_o | output | LANES*ERR_W | Per-lane error counts, lane i at bits [i*ERR_W +: ERR_W] |
| done_o | output | 1 | One-cycle pulse after each full generator sweep |

## Verification
A wrong shift-register tap or seed fix-up shows on `tx_data_o` within a few cycles of start. A wrong dwell count or wrap point shows as the victim bit appearing on the wrong lane, and as `done_o` firing in the wrong cycle, within one sweep. A checker schedule that is off by even one cycle from the generator shows as non-zero error counters right after the latency window, while the loopback data is clean. Freeze and saturation faults show as counters that move after a stop, or that move past or fall from the maximum.

// File: rtl/lane_stress_pkg.sv
package lane_stress_pkg;

    localparam int VIC_W  = 7;
    localparam int AGG_W  = 15;
    localparam int SEED_W = AGG_W;

    function automatic logic [VIC_W-1:0] vic_step(input logic [VIC_W-1:0] s);
        return {s[VIC_W-2:0], s[VIC_W-1] ^ s[VIC_W-2]};
    endfunction

    function automatic logic [AGG_W-1:0] agg_step(input logic [AGG_W-1:0] s);
        return {s[AGG_W-2:0], s[AGG_W-1] ^ s[AGG_W-2]};
    endfunction

    function automatic logic [VIC_W-1:0] vic_seed(input logic [SEED_W-1:0] s);
        return (s[VIC_W-1:0] == '0) ? VIC_W'(1) : s[VIC_W-1:0];
    endfunction

    function automatic logic [AGG_W-1:0] agg_seed(input logic [SEED_W-1:0] s);
        return (s == '0) ? AGG_W'(1) : s;
    endfunction

endpackage

// File: rtl/lsg_pattern_engine.sv
module lsg_pattern_engine
    import lane_stress_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int INTV_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 step_i,
    input  logic [SEED_W-1:0]    seed_i,
    input  logic [INTV_W-1:0]    interval_i,
    output logic [LANES-1:0]     pat_o,
    output logic                 wrap_o
);

    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(LANES - 1);

    typedef struct packed {
        logic [VIC_W-1:0]  vic;
        logic [AGG_W-1:0]  agg;
        logic [IDX_W-1:0]  victim;
        logic [INTV_W-1:0] dwell;
    } eng_t;

    eng_t q, d;
    logic [INTV_W-1:0] dwell_last;
    logic              wrap_d;

    always_comb begin
        d          = q;
        wrap_d     = 1'b0;
        dwell_last = (interval_i == '0) ? '0 : interval_i - INTV_W'(1);
        if (load_i) begin
            d.vic    = vic_seed(seed_i);
            d.agg    = agg_seed(seed_i);
            d.victim = '0;
            d.dwell  = '0;
        end else if (step_i) begin
            d.vic = vic_step(q.vic);
            d.agg = agg_step(q.agg);
            if (q.dwell >= dwell_last) begin
                d.dwell = '0;
                if (q.victim == LAST_LANE) begin
                    d.victim = '0;
                    wrap_d   = 1'b1;
                end else begin
                    d.victim = q.victim + IDX_W'(1);
                end
            end else begin
                d.dwell = q.dwell + INTV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.vic    <= VIC_W'(1);
            q.agg    <= AGG_W'(1);
            q.victim <= '0;
            q.dwell  <= '0;
        end else begin
            q <= d;
        end
    end

    assign wrap_o = wrap_d;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic INV = 1'(l % 2);
        assign pat_o[l] = (q.victim == IDX_W'(l)) ? q.vic[VIC_W-1]
                                                   : (q.agg[AGG_W-1] ^ INV);
    end

endmodule

// File: rtl/lsg_err_bank.sv
module lsg_err_bank #(
    parameter int LANES = 8,
    parameter int ERR_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic                   en_i,
    input  logic [LANES-1:0]       mism_i,
    output logic [LANES*ERR_W-1:0] cnt_o
);

    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic [LANES-1:0][ERR_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        for (int l = 0; l < LANES; l++) begin
            if (clr_i) begin
                cnt_d[l] = '0;
            end else if (en_i && mism_i[l] && cnt_q[l] != CNT_MAX) begin
                cnt_d[l] = cnt_q[l] + ERR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/lane_stress_gen.sv
module lane_stress_gen
    import lane_stress_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int INTV_W = 16,
    parameter int LAT_W  = 4,
    parameter int ERR_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   stop_i,
    input  logic [SEED_W-1:0]      seed_i,
    input  logic [INTV_W-1:0]      interval_i,
    input  logic [LAT_W-1:0]       lat_i,
    input  logic [LANES-1:0]       rx_data_i,
    output logic [LANES-1:0]       tx_data_o,
    output logic [LANES*ERR_W-1:0] err_cnt_o,
    output logic                   done_o
);

    typedef struct packed {
        logic              run;
        logic [LAT_W-1:0]  wait_cnt;
        logic [INTV_W-1:0] interval;
        logic              done;
    } ctl_t;

    ctl_t q, d;

    logic             gen_step, chk_step;
    logic             gen_wrap, chk_wrap;
    logic [LANES-1:0] gen_pat, chk_pat;

    always_comb begin
        d        = q;
        gen_step = q.run && !stop_i && !start_i;
        chk_step = gen_step && (q.wait_cnt == '0);
        d.done   = gen_wrap;
        if (start_i) begin
            d.run      = 1'b1;
            d.wait_cnt = lat_i;
            d.interval = interval_i;
            d.done     = 1'b0;
        end else if (stop_i) begin
            d.run = 1'b0;
        end else if (q.run && q.wait_cnt != '0) begin
            d.wait_cnt = q.wait_cnt - LAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.run      <= 1'b0;
            q.wait_cnt <= '0;
            q.interval <= '0;
            q.done     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    lsg_pattern_engine #(.LANES(LANES), .INTV_W(INTV_W)) u_gen_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_i),
        .step_i     (gen_step),
        .seed_i     (seed_i),
        .interval_i (q.interval),
        .pat_o      (gen_pat),
        .wrap_o     (gen_wrap)
    );

    lsg_pattern_engine #(.LANES(LANES), .INTV_W(INTV_W)) u_chk_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_i),
        .step_i     (chk_step),
        .seed_i     (seed_i),
        .interval_i (q.interval),
        .pat_o      (chk_pat),
        .wrap_o     (chk_wrap)
    );

    lsg_err_bank #(.LANES(LANES), .ERR_W(ERR_W)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .en_i   (chk_step),
        .mism_i (rx_data_i ^ chk_pat),
        .cnt_o  (err_cnt_o)
    );

    assign tx_data_o = gen_pat;
    assign done_o    = q.done;

endmodule

// File: rtl/lane_stress_gen_props.sv
module lane_stress_gen_props #(
    parameter int LANES = 8,
    parameter int ERR_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   stop_i,
    input logic [LANES-1:0]       tx_data_o,
    input logic [LANES*ERR_W-1:0] err_cnt_o,
    input logic                   done_o,
    input logic                   chk_wrap
);

    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (err_cnt_o == '0) && !done_o);

    // R8
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> $stable(tx_data_o) && $stable(err_cnt_o));

    // R9
    chk_sched_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_wrap |-> !start_i && !stop_i);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // R10
        cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !start_i |=> err_cnt_o[l*ERR_W +: ERR_W] >= $past(err_cnt_o[l*ERR_W +: ERR_W]));
        // R11
        cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (err_cnt_o[l*ERR_W +: ERR_W] == CNT_MAX && !start_i)
            |=> err_cnt_o[l*ERR_W +: ERR_W] == CNT_MAX);
    end

endmodule

bind lane_stress_gen lane_stress_gen_props #(.LANES(LANES), .ERR_W(ERR_W)) u_props (.*);

// File: tb/lane_stress_gen_bench.sv
module lane_stress_gen_bench;

    localparam int LANES  = 8;
    localparam int INTV_W = 16;
    localparam int LAT_W  = 4;
    localparam int ERR_W  = 16;
    localparam int LAT    = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start_i = 1'b0;
    logic                   stop_i = 1'b0;
    logic [14:0]            seed_i = '0;
    logic [INTV_W-1:0]      interval_i = '0;
    logic [LAT_W-1:0]       lat_i = LAT_W'(LAT);
    logic [LANES-1:0]       rx_data_i;
    logic [LANES-1:0]       tx_data_o;
    logic [LANES*ERR_W-1:0] err_cnt_o;
    logic                   done_o;

    logic [LANES-1:0] inj = '0;
    logic [LANES-1:0] p0 = '0, p1 = '0, p2 = '0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        p0 <= tx_data_o;
        p1 <= p0;
        p2 <= p1;
    end
    assign rx_data_i = p2 ^ inj;

    lane_stress_gen #(.LANES(LANES), .INTV_W(INTV_W), .LAT_W(LAT_W), .ERR_W(ERR_W)) u_lane_stress_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .seed_i(seed_i),
        .interval_i(interval_i), .lat_i(lat_i), .rx_data_i(rx_data_i),
        .tx_data_o(tx_data_o), .err_cnt_o(err_cnt_o), .done_o(done_o)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    // independent reference of the transmit side
    logic [6:0]        mv = 7'd1;
    logic [14:0]       ma = 15'd1;
    int                mvic = 0;
    int                mcnt = 0;
    logic [INTV_W-1:0] mint = '0;
    bit                mrun = 0;
    bit                mdone = 0;

    logic [LANES-1:0] exp_tx_q[$];
    logic             exp_done_q[$];

    function automatic logic [LANES-1:0] model_tx();
        logic [LANES-1:0] t;
        for (int l = 0; l < LANES; l++)
            t[l] = (l == mvic) ? mv[6] : (ma[14] ^ logic'(l % 2));
        return t;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int lane_err(input int l);
        return int'(err_cnt_o[l*ERR_W +: ERR_W]);
    endfunction

    // driver: advance reference on every edge, push expected outputs
    task automatic cyc();
        int last;
        @(posedge clk);
        if (start_i) begin
            mv = (seed_i[6:0] == 0) ? 7'd1 : seed_i[6:0];
            ma = (seed_i == 0) ? 15'd1 : seed_i;
            mvic = 0; mcnt = 0; mint = interval_i; mrun = 1; mdone = 0;
        end else if (stop_i) begin
            mrun = 0; mdone = 0;
        end else if (mrun) begin
            mv = {mv[5:0], mv[6] ^ mv[5]};
            ma = {ma[13:0], ma[14] ^ ma[13]};
            mdone = 0;
            last = (mint == 0) ? 0 : int'(mint) - 1;
            if (mcnt >= last) begin
                mcnt = 0;
                if (mvic == LANES - 1) begin mvic = 0; mdone = 1; end
                else mvic = mvic + 1;
            end else begin
                mcnt = mcnt + 1;
            end
        end else begin
            mdone = 0;
        end
        #1;
        exp_tx_q.push_back(model_tx());
        exp_done_q.push_back(mdone);
    endtask

    // monitor: pop and compare between edges (R2 R3 R4 R5 R6)
    always @(negedge clk) begin
        if (exp_tx_q.size() > 0) begin
            logic [LANES-1:0] et;
            logic             ed;
            et = exp_tx_q.pop_front();
            ed = exp_done_q.pop_front();
            check(tx_data_o === et, "R4 tx lanes", tx_data_o, et);
            check(done_o === ed, "R6 done", done_o, ed);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [LANES-1:0] held;
        int               held_e3;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_data_o === 8'hAA, "R1 reset tx", tx_data_o, 8'hAA);
        check(err_cnt_o === '0, "R1 reset counters", err_cnt_o, 0);
        check(done_o === 1'b0, "R1 reset done", done_o, 0);

        // R2 R3 R5 R6: two sweeps, dwell 3, clean loopback
        seed_i = 15'h1234; interval_i = 16'd3;
        @(posedge clk); #1 start_i = 1'b1;
        cyc(); start_i = 1'b0;
        repeat (60) cyc();
        for (int l = 0; l < LANES; l++)
            check(lane_err(l) == 0, "R10 clean loopback", lane_err(l), 0);

        // R9: mismatches inside latency window ignored, then counted (R10)
        seed_i = 15'h4d2b; interval_i = 16'd2;
        start_i = 1'b1; cyc(); start_i = 1'b0;
        inj = 8'h08;
        repeat (LAT) cyc();
        inj = '0;
        check(lane_err(3) == 0, "R9 latency window", lane_err(3), 0);
        inj = 8'h08;
        repeat (4) cyc();
        inj = '0;
        check(lane_err(3) == 4, "R10 lane3 count", lane_err(3), 4);
        check(lane_err(2) == 0, "R10 lane2 untouched", lane_err(2), 0);
        repeat (10) cyc();
        check(lane_err(3) == 4, "R10 no spurious count", lane_err(3), 4);

        // R8: stop freezes outputs and counters
        stop_i = 1'b1; cyc(); stop_i = 1'b0;
        held = tx_data_o;
        held_e3 = lane_err(3);
        inj = 8'h20;
        repeat (5) cyc();
        inj = '0;
        check(lane_err(5) == 0, "R8 frozen lane5", lane_err(5), 0);
        check(lane_err(3) == held_e3, "R8 frozen lane3", lane_err(3), held_e3);
        check(tx_data_o === held, "R8 frozen tx", tx_data_o, held);

        // R7: start wins over stop; zero seed and zero interval
        seed_i = '0; interval_i = '0;
        start_i = 1'b1; stop_i = 1'b1; cyc(); start_i = 1'b0; stop_i = 1'b0;
        check(err_cnt_o === '0, "R7 start clears", err_cnt_o, 0);
        repeat (20) cyc();
        for (int l = 0; l < LANES; l++)
            check(lane_err(l) == 0, "R7 running after start", lane_err(l), 0);

        // R11: saturation on lane 0
        inj = 8'h01;
        repeat (65600) cyc();
        inj = '0;
        check(lane_err(0) == 65535, "R11 saturate", lane_err(0), 65535);
        check(lane_err(1) == 0, "R11 neighbour", lane_err(1), 0);
        repeat (3) cyc();
        check(lane_err(0) == 65535, "R11 hold", lane_err(0), 65535);

        start_i = 1'b1; cyc(); start_i = 1'b0;
        check(lane_err(0) == 0, "R7 clear after saturation", lane_err(0), 0);
        cyc();
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule